// File: doc/BRIEF.md
# Two-Channel Split-Phase Pulse Generator

This block drives two pulse-width outputs from one system clock. Each channel is set up by two 16-bit lengths: how many prescaled ticks the output stays high, and how many it then stays low. The pattern repeats for as long as the channel is enabled. One control word is shared by both channels. For each channel it holds an output enable, a prescaler run bit, a 7-bit divide value and a 2-bit choice among four source tick strobes.

Software reaches the block through a flat word-addressed write port with a combinational read-back. The source strobes are one-cycle enables in the same clock domain, so no real clock is switched. A channel counts on each selected source strobe that its prescaler passes. Lengths and the divide value are latched at each period boundary, so a rewrite never truncates a phase already in progress.

Top module: `pwm2_top`

## Requirements
- R1: The channel 0 length word is at byte address 0x0, the channel 1 length word at 0x4 and the control word at 0x8. A read returns the last value written. Control bits outside 0,1,4..23 read as zero. Any other address reads zero and ignores writes.
- R2: In a length word, bits 31:16 hold the high length and bits 15:0 hold the low length, both unsigned.
- R3: Control bit 0 enables channel 0 and bit 1 enables channel 1. While its enable is clear, a channel drives its output low and holds its counters cleared.
- R4: Bits 5:4 (channel 0) and bits 7:6 (channel 1) pick which of the four source strobes feeds the prescaler. A strobe that never pulses freezes the waveform.
- R5: Bits 14:8 (channel 0) and bits 22:16 (channel 1) hold a divide value N. The prescaler passes one tick per N+1 selected strobes.
- R6: Bit 15 (channel 0) and bit 23 (channel 1) let the prescaler run. While the bit is clear, the waveform does not advance.
- R7: Each period lasts high+low prescaled ticks. The output is high for the first high ticks and low for the rest, repeating.
- R8: A high length of zero keeps the output low. A low length of zero with a nonzero high length keeps it high. Both zero keeps it low.
- R9: Lengths and divide value written while a channel runs take effect only at the next period start. The current high and low phases run to their old lengths.
- R10: After reset all three registers read zero and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_addr | input | 4 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| src_tick | input | 4 | Four single-cycle source strobes |
| pwm_out | output | 2 | Channel outputs, bit c for channel c |

## Verification
A wrong position counter, or a period length latched wrongly, changes the ratio of high cycles to total cycles over any whole number of periods. A measurement window two periods long therefore exposes it within one period of the fault. A prescaler that miscounts stretches every period by the source spacing, which shows in the same window. A reload taken at the wrong moment shortens the phase in progress. Measuring the low run and the high run that follow a mid-phase rewrite catches this within one period.

// File: rtl/pwm2_pkg.sv
package pwm2_pkg;
  localparam int CNT_W  = 16;
  localparam int DIV_W  = 7;
  localparam int SEL_W  = 2;
  localparam int NSRC   = 1 << SEL_W;
  localparam int NCH    = 2;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 4;
  localparam logic [REG_W-1:0] CTRL_MASK = 32'h00FF_FFF3;

  typedef struct packed {
    logic             out_en;
    logic             clk_en;
    logic [DIV_W-1:0] div;
    logic [SEL_W-1:0] sel;
    logic [CNT_W-1:0] hi;
    logic [CNT_W-1:0] lo;
  } ch_cfg_t;

  // Pull one channel's settings out of its length word and the shared control word.
  function automatic ch_cfg_t decode_cfg(input int ch, input logic [REG_W-1:0] len_word,
                                         input logic [REG_W-1:0] ctrl);
    ch_cfg_t c;
    c.out_en = ctrl[ch];
    c.sel    = ctrl[4 + 2*ch +: SEL_W];
    c.div    = ctrl[8 + 8*ch +: DIV_W];
    c.clk_en = ctrl[15 + 8*ch];
    c.hi     = len_word[2*CNT_W-1:CNT_W];
    c.lo     = len_word[CNT_W-1:0];
    return c;
  endfunction

  function automatic logic [CNT_W:0] period_len(input logic [CNT_W-1:0] hi,
                                               input logic [CNT_W-1:0] lo);
    return {1'b0, hi} + {1'b0, lo};
  endfunction
endpackage

// File: rtl/pwm2_regs.sv
module pwm2_regs
  import pwm2_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [REG_W-1:0]          wdata_i,
  output logic [REG_W-1:0]          rdata_o,
  output logic [NCH-1:0][REG_W-1:0] len_o,
  output logic [REG_W-1:0]          ctrl_o
);
  logic [NCH-1:0][REG_W-1:0] len_q;
  logic [REG_W-1:0]          ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q  <= '0;
      ctrl_q <= '0;
    end else if (wr_i) begin
      case (addr_i)
        4'h0:    len_q[0] <= wdata_i;
        4'h4:    len_q[1] <= wdata_i;
        4'h8:    ctrl_q   <= wdata_i & CTRL_MASK;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr_i)
      4'h0:    rdata_o = len_q[0];
      4'h4:    rdata_o = len_q[1];
      4'h8:    rdata_o = ctrl_q;
      default: rdata_o = '0;
    endcase
  end

  assign len_o  = len_q;
  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/pwm2_prescale.sv
module pwm2_prescale
  import pwm2_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             clken_i,
  input  logic [NSRC-1:0]  src_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             ptick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             adv;

  assign adv     = run_i && clken_i && src_i[sel_i];
  assign ptick_o = adv && (cnt_q == div_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (adv)     cnt_q <= ptick_o ? '0 : cnt_q + 1'b1;
  end

  // R6: a gated prescaler keeps its count
  assert_hold_when_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !clken_i) |=> $stable(cnt_q));
  // R5: the count never passes the latched divide value
  assert_count_below_div_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= div_i);
endmodule

// File: rtl/pwm2_phase.sv
module pwm2_phase
  import pwm2_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [CNT_W-1:0] hi_i,
  input  logic [CNT_W-1:0] lo_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             ptick_i,
  output logic             run_o,
  output logic [DIV_W-1:0] div_o,
  output logic             out_o
);
  localparam logic [CNT_W:0] ONE = 1;

  logic             run_q;
  logic [CNT_W:0]   pos_q;
  logic [CNT_W-1:0] hi_q, lo_q;
  logic [DIV_W-1:0] div_q;
  logic [CNT_W:0]   plen;
  logic             wrap;

  assign plen = period_len(hi_q, lo_q);
  assign wrap = ptick_i && ((plen == '0) || (pos_q == plen - ONE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      pos_q <= '0;
      hi_q  <= '0;
      lo_q  <= '0;
      div_q <= '0;
    end else if (!en_i) begin
      run_q <= 1'b0;
      pos_q <= '0;
    end else if (!run_q || wrap) begin
      run_q <= 1'b1;
      pos_q <= '0;
      hi_q  <= hi_i;
      lo_q  <= lo_i;
      div_q <= div_i;
    end else if (ptick_i) begin
      pos_q <= pos_q + ONE;
    end
  end

  assign run_o = run_q;
  assign div_o = div_q;
  assign out_o = en_i && run_q && (pos_q < {1'b0, hi_q});

  // R3: a disabled channel has its state cleared on the next edge
  assert_cleared_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (!run_q && pos_q == '0));
  // R7: the position stays inside the period
  assert_pos_in_period_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && plen != '0) |-> (pos_q < plen));
  // R9: latched settings move only at a period boundary
  assert_latch_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && run_q && !wrap) |=> ($stable(hi_q) && $stable(lo_q) && $stable(div_q)));
  // R8: zero high length never drives high
  assert_zero_high_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && hi_q == '0) |-> !out_o);
endmodule

// File: rtl/pwm2_top.sv
module pwm2_top
  import pwm2_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [NSRC-1:0]   src_tick,
  output logic [NCH-1:0]    pwm_out
);
  logic [NCH-1:0][REG_W-1:0] len_w;
  logic [REG_W-1:0]          ctrl_w;

  pwm2_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr), .addr_i(reg_addr),
    .wdata_i(reg_wdata), .rdata_o(reg_rdata), .len_o(len_w), .ctrl_o(ctrl_w)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    ch_cfg_t          cfg;
    logic             ptick, run;
    logic [DIV_W-1:0] div_l;

    assign cfg = decode_cfg(c, len_w[c], ctrl_w);

    pwm2_prescale u_pre (
      .clk(clk), .rst_n(rst_n), .run_i(run), .clken_i(cfg.clk_en),
      .src_i(src_tick), .sel_i(cfg.sel), .div_i(div_l), .ptick_o(ptick)
    );

    pwm2_phase u_phase (
      .clk(clk), .rst_n(rst_n), .en_i(cfg.out_en), .hi_i(cfg.hi), .lo_i(cfg.lo),
      .div_i(cfg.div), .ptick_i(ptick), .run_o(run), .div_o(div_l), .out_o(pwm_out[c])
    );
  end
endmodule

// File: tb/sim_pwm2_top.sv
module sim_pwm2_top;
  logic        clk = 0, rst_n = 0, reg_wr = 0;
  logic [3:0]  reg_addr = 0, src_tick = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [1:0]  pwm_out;
  int tests = 0, fails = 0, cyc = 0;
  bit done = 0;

  pwm2_top u0 (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_tick(src_tick), .pwm_out(pwm_out));

  always #10 clk = ~clk;

  // sources: 0 every cycle, 1 every 2nd, 2 every 3rd, 3 never
  always @(negedge clk) begin
    cyc <= cyc + 1;
    src_tick <= {1'b0, (cyc % 3) == 0, (cyc % 2) == 0, 1'b1};
  end

  // {ch, hi, lo, div, sel}
  localparam int NV = 8;
  localparam int VEC [NV][5] = '{
    '{0, 3, 5, 0, 0}, '{1, 2, 2, 1, 0}, '{0, 1, 3, 2, 1}, '{1, 4, 1, 0, 2},
    '{0, 0, 4, 0, 0}, '{1, 5, 0, 1, 1}, '{0, 0, 0, 0, 0}, '{1, 7, 9, 3, 2}};

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  function automatic logic [31:0] ctrl_for(int ch, int div, int sel, bit clken);
    logic [31:0] v = 0;
    v[ch] = 1'b1;
    v[15 + 8*ch] = clken;
    v[8 + 8*ch +: 7] = div[6:0];
    v[4 + 2*ch +: 2] = sel[1:0];
    return v;
  endfunction

  task automatic window(input int ch, input int n, output int hc, output int oc);
    hc = 0; oc = 0;
    for (int i = 0; i < n; i++) begin
      if (pwm_out[ch]) hc++;
      if (pwm_out[1-ch]) oc++;
      @(negedge clk);
    end
  endtask

  task automatic run_len(input int ch, input logic lvl, output int n);
    n = 0;
    while (pwm_out[ch] !== lvl) @(negedge clk);
    while (pwm_out[ch] === lvl && n < 1000) begin n++; @(negedge clk); end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R7 watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int hc, oc, n, s, per;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10: reset state
    rd(4'h0, d); chk("R10 len0 reset", d, 0);
    rd(4'h4, d); chk("R10 len1 reset", d, 0);
    rd(4'h8, d); chk("R10 ctrl reset", d, 0);
    chk("R10 outputs low", pwm_out, 0);

    // R1: read-back, masking, unmapped address
    wr(4'h0, 32'hDEADBEEF); rd(4'h0, d); chk("R1 len0 readback", d, 32'hDEADBEEF);
    wr(4'h4, 32'h12345678); rd(4'h4, d); chk("R1 len1 readback", d, 32'h12345678);
    wr(4'hC, 32'hFFFFFFFF); rd(4'hC, d); chk("R1 unmapped reads zero", d, 0);
    rd(4'h0, d); chk("R1 unmapped write ignored", d, 32'hDEADBEEF);
    wr(4'h8, 32'hFFFFFFFF); rd(4'h8, d); chk("R1 ctrl unused bits zero", d, 32'h00FFFFF3);
    wr(4'h8, 0);

    // R7 R5 R4 R8 R2: table of settings, high cycles over two full periods
    for (int v = 0; v < NV; v++) begin
      s = VEC[v][4] + 1;
      per = (VEC[v][1] + VEC[v][2]) * (VEC[v][3] + 1) * s;
      wr(4'h8, 0);
      wr(VEC[v][0] ? 4'h4 : 4'h0, {VEC[v][1][15:0], VEC[v][2][15:0]});
      wr(4'h8, ctrl_for(VEC[v][0], VEC[v][3], VEC[v][4], 1'b1));
      repeat (4) @(negedge clk);
      n = (per == 0) ? 50 : 2 * per;
      window(VEC[v][0], n, hc, oc);
      chk($sformatf("R7 R5 R4 R8 vector %0d high cycles", v), hc,
          (per == 0) ? 0 : 2 * VEC[v][1] * (VEC[v][3] + 1) * s);
      chk($sformatf("R3 vector %0d idle channel low", v), oc, 0);
    end

    // R2: high length in upper half, zero low length gives steady high
    wr(4'h8, 0); wr(4'h0, 32'h0001_0000); wr(4'h8, ctrl_for(0, 0, 0, 1'b1));
    repeat (3) @(negedge clk);
    window(0, 20, hc, oc); chk("R2 upper half is high length", hc, 20);

    // R6: prescaler gated freezes the waveform, then runs
    wr(4'h8, 0); wr(4'h0, 32'h0002_0002); wr(4'h8, ctrl_for(0, 0, 0, 1'b0));
    repeat (3) @(negedge clk);
    window(0, 30, hc, oc); chk("R6 gated prescaler frozen high", hc, 30);
    wr(4'h8, ctrl_for(0, 0, 0, 1'b1));
    repeat (3) @(negedge clk);
    window(0, 40, hc, oc); chk("R6 released prescaler duty", hc, 20);

    // R3: clearing the enable drops the output
    wr(4'h8, 0);
    window(0, 10, hc, oc); chk("R3 disabled output low", hc, 0);

    // R4: a silent source freezes the channel
    wr(4'h0, 32'h0001_0001); wr(4'h8, ctrl_for(0, 0, 3, 1'b1));
    repeat (3) @(negedge clk);
    window(0, 20, hc, oc); chk("R4 silent source frozen", hc, 20);

    // R9: mid-phase rewrite waits for the period boundary
    wr(4'h8, 0); wr(4'h0, 32'h0008_0008); wr(4'h8, ctrl_for(0, 0, 0, 1'b1));
    repeat (3) @(negedge clk);
    wr(4'h0, 32'h0002_0002);
    run_len(0, 1'b0, n); chk("R9 old low phase kept", n, 8);
    run_len(0, 1'b1, n); chk("R9 new high length next period", n, 2);
    run_len(0, 1'b0, n); chk("R9 new low length next period", n, 2);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule